// File: doc/BRIEF.md
# Scan Test Sequencer

This block drives a short chain of mux-D scan flip-flops that surround a small combinational logic cone, and runs a complete stuck-at test on it. A test starts when the caller offers a stimulus vector and the fault-free response expected for it. The block then loads the stimulus serially with scan enable high. It drops scan enable for exactly one functional clock, so that every flop captures the cone's output. It raises scan enable again and unloads the captured response. Each bit that emerges at the chain tail is compared with the expected value, and any difference raises a sticky fail flag.

A follow-on stimulus may be offered during the capture cycle. In that case the unload of the current response and the load of the next stimulus share the same shift clocks, which saves one full chain length per extra pattern. The cone has a fault-injection input that pins one of its internal AND nets to a chosen level. This lets a stuck-at defect be emulated and its detection observed at the ports.

Top module: `scan_seq_top`

## Requirements
- R1: After reset, busy, done, fail and scan_enable are all low.
- R2: A start taken while idle loads the stimulus over CHAIN_LEN cycles with scan_enable high. scan_in presents pattern[CHAIN_LEN-1] first, then the lower indices one per cycle. After the load, flop i (flop 0 sits next to scan_in, and scan_out is the last flop) holds pattern[i], so scan_out equals pattern[CHAIN_LEN-1] during the capture cycle.
- R3: Exactly one cycle with scan_enable low separates the load from the unload. On that clock every flop loads its cone output.
- R4: The cone computes net[i] = q[i] AND q[(i+1) mod CHAIN_LEN] and resp[i] = net[i] XOR q[(i+2) mod CHAIN_LEN], where q is the chain content.
- R5: In the j-th shift cycle after a capture (j counted from 0), scan_out shows resp[CHAIN_LEN-1-j].
- R6: The bit seen in the j-th unload cycle is compared with expected[CHAIN_LEN-1-j]. Any difference sets fail.
- R7: With fault_en high, net[fault_sel] is forced to fault_val. A fault_sel of CHAIN_LEN or more, or fault_en low, leaves the cone fault-free.
- R8: fail is cleared only when a start is taken from idle. Once set, it stays high through later patterns of the same run and after done.
- R9: A start held high in the capture cycle chains the next pattern, and its load overlaps the previous unload. Two chained patterns keep busy high for 3*CHAIN_LEN+2 cycles, and done pulses once per pattern.
- R10: A single pattern keeps busy high for 2*CHAIN_LEN+1 cycles from the cycle after the start. done is a one-cycle pulse in the cycle after the last compare, and busy is low in that cycle.
- R11: A start raised while busy outside the capture cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Offer a pattern (taken when idle or in the capture cycle) |
| pattern | input | CHAIN_LEN | Stimulus, bit i destined for flop i |
| expected | input | CHAIN_LEN | Fault-free response, bit i for flop i |
| fault_en | input | 1 | Enable forcing of one cone net |
| fault_sel | input | SELW | Index of the forced net |
| fault_val | input | 1 | Level the forced net takes |
| scan_in | output | 1 | Serial bit entering the chain head |
| scan_out | output | 1 | Chain tail bit |
| scan_enable | output | 1 | High selects shift, low selects functional capture |
| busy | output | 1 | A pattern is in flight |
| done | output | 1 | One-cycle pulse after each response is compared |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The bench checks serial bit order in both directions. Loading the stimulus in ascending order would put the wrong value in front of the tail during capture, and unloading in ascending order would scramble the response stream in the scoreboard. It chains a pattern during the capture cycle and counts busy cycles. A design without overlapped unload and load runs three cycles long, and a design that drops the chained start loses a done pulse. It injects stuck-at-0 and stuck-at-1 faults both with stimuli that excite them and with stimuli that mask them, so a comparator that is too eager or too lax shows up as a wrong fail. It also checks that fail survives a clean pattern chained after a failing one, and that a stray start during shifting leaves the response unchanged.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAPT  = 2'd2
  } seq_state_e;

  // Neighbour index on the ring of chain positions.
  function automatic int ring_idx(input int i, input int off, input int n);
    return (i + off) % n;
  endfunction

  // Width of a counter that spans n positions (at least one bit).
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic se,
  input  logic ti,
  input  logic fd,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= se ? ti : fd;
  end
endmodule

// File: rtl/scan_cone.sv
module scan_cone #(
  parameter int N    = 3,
  parameter int SELW = 2
) (
  input  logic [N-1:0]    q,
  input  logic            fault_en,
  input  logic [SELW-1:0] fault_sel,
  input  logic            fault_val,
  output logic [N-1:0]    and_net,
  output logic [N-1:0]    resp
);
  for (genvar i = 0; i < N; i++) begin : g_term
    localparam int J = scan_seq_pkg::ring_idx(i, 1, N);
    localparam int K = scan_seq_pkg::ring_idx(i, 2, N);
    logic raw;
    logic hit;
    assign raw        = q[i] & q[J];
    assign hit        = fault_en && (fault_sel == SELW'(i));
    assign and_net[i] = hit ? fault_val : raw;
    assign resp[i]    = and_net[i] ^ q[K];
  end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         se,
  input  logic         si,
  input  logic [N-1:0] fd,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    logic ti_w;
    if (i == 0) begin : g_head
      assign ti_w = si;
    end else begin : g_link
      assign ti_w = q[i-1];
    end
    scan_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .se   (se),
      .ti   (ti_w),
      .fd   (fd[i]),
      .q    (q[i])
    );
  end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] pattern,
  input  logic [N-1:0] expected,
  input  logic         chain_tail,
  output logic         scan_en,
  output logic         scan_si,
  output logic         busy,
  output logic         done,
  output logic         fail,
  output logic         shift_fire,
  output logic         capt_fire,
  output logic         cmp_valid,
  output logic         mismatch
);
  import scan_seq_pkg::*;

  localparam int CW = cnt_width(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  seq_state_e      state;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   pos;
  logic [N-1:0]    pat_q;
  logic [N-1:0]    exp_cur;
  logic [N-1:0]    exp_nxt;
  logic            load_act;
  logic            cmp_act;
  logic            last;
  logic            start_idle;
  logic            start_chain;
  logic            exp_bit;

  always_comb begin
    shift_fire  = (state == ST_SHIFT);
    capt_fire   = (state == ST_CAPT);
    busy        = (state != ST_IDLE);
    scan_en     = shift_fire;
    last        = (cnt == LAST);
    pos         = LAST - cnt;
    scan_si     = load_act & pat_q[pos];
    exp_bit     = exp_cur[pos];
    cmp_valid   = shift_fire & cmp_act;
    mismatch    = cmp_valid & (chain_tail != exp_bit);
    start_idle  = start & (state == ST_IDLE);
    start_chain = start & capt_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      pat_q    <= '0;
      exp_cur  <= '0;
      exp_nxt  <= '0;
      load_act <= 1'b0;
      cmp_act  <= 1'b0;
      fail     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= cmp_valid & last;
      if (start_idle)    fail <= 1'b0;
      else if (mismatch) fail <= 1'b1;

      unique case (state)
        ST_IDLE: begin
          if (start_idle) begin
            pat_q    <= pattern;
            exp_nxt  <= expected;
            load_act <= 1'b1;
            cmp_act  <= 1'b0;
            cnt      <= '0;
            state    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (last) begin
            cnt <= '0;
            if (load_act) begin
              state <= ST_CAPT;
            end else begin
              state   <= ST_IDLE;
              cmp_act <= 1'b0;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_CAPT: begin
          exp_cur <= exp_nxt;
          cmp_act <= 1'b1;
          cnt     <= '0;
          state   <= ST_SHIFT;
          if (start_chain) begin
            pat_q    <= pattern;
            exp_nxt  <= expected;
            load_act <= 1'b1;
          end else begin
            load_act <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
  parameter  int CHAIN_LEN = 3,
  localparam int SELW      = scan_seq_pkg::cnt_width(CHAIN_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CHAIN_LEN-1:0] pattern,
  input  logic [CHAIN_LEN-1:0] expected,
  input  logic                 fault_en,
  input  logic [SELW-1:0]      fault_sel,
  input  logic                 fault_val,
  output logic                 scan_in,
  output logic                 scan_out,
  output logic                 scan_enable,
  output logic                 busy,
  output logic                 done,
  output logic                 fail
);
  logic [CHAIN_LEN-1:0] chain_q;
  logic [CHAIN_LEN-1:0] cone_resp;
  logic [CHAIN_LEN-1:0] cone_net;
  logic                 shift_fire;
  logic                 capt_fire;
  logic                 cmp_valid;
  logic                 mismatch;

  assign scan_out = chain_q[CHAIN_LEN-1];

  scan_ctrl #(.N(CHAIN_LEN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pattern   (pattern),
    .expected  (expected),
    .chain_tail(scan_out),
    .scan_en   (scan_enable),
    .scan_si   (scan_in),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .shift_fire(shift_fire),
    .capt_fire (capt_fire),
    .cmp_valid (cmp_valid),
    .mismatch  (mismatch)
  );

  scan_chain #(.N(CHAIN_LEN)) u_chain (
    .clk  (clk),
    .rst_n(rst_n),
    .se   (scan_enable),
    .si   (scan_in),
    .fd   (cone_resp),
    .q    (chain_q)
  );

  scan_cone #(.N(CHAIN_LEN), .SELW(SELW)) u_cone (
    .q        (chain_q),
    .fault_en (fault_en),
    .fault_sel(fault_sel),
    .fault_val(fault_val),
    .and_net  (cone_net),
    .resp     (cone_resp)
  );
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         fail,
  input logic         scan_enable,
  input logic         scan_in,
  input logic [N-1:0] chain_q,
  input logic [N-1:0] cone_resp,
  input logic         shift_fire,
  input logic         capt_fire,
  input logic         mismatch
);
  a_r2_shift_head: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> chain_q[0] == $past(scan_in));

  a_r2_shift_body: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> chain_q[N-1:1] == $past(chain_q[N-2:0]));

  a_r3_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    capt_fire |=> chain_q == $past(cone_resp));

  a_r3_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capt_fire |=> scan_enable);

  a_r6_fail_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(mismatch));

  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && !busy)) |=> fail);

  a_r10_busy_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind scan_seq_top scan_seq_chk #(.N(CHAIN_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .fail       (fail),
  .scan_enable(scan_enable),
  .scan_in    (scan_in),
  .chain_q    (chain_q),
  .cone_resp  (cone_resp),
  .shift_fire (shift_fire),
  .capt_fire  (capt_fire),
  .mismatch   (mismatch)
);

// File: tb/tb_scan_seq_top.sv
module tb_scan_seq_top;
  localparam int L = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] pattern = '0;
  logic [2:0] expected = '0;
  logic       fault_en = 1'b0;
  logic [1:0] fault_sel = '0;
  logic       fault_val = 1'b0;
  logic       scan_in, scan_out, scan_enable, busy, done, fail;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit fail_acc = 0;
  int unload_left = 0;
  logic [2:0] got = '0;

  logic [2:0] resp_q[$];
  logic       fail_q[$];
  logic       head_q[$];

  always #2 clk = ~clk;

  scan_seq_top #(.CHAIN_LEN(L)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern),
    .expected(expected), .fault_en(fault_en), .fault_sel(fault_sel),
    .fault_val(fault_val), .scan_in(scan_in), .scan_out(scan_out),
    .scan_enable(scan_enable), .busy(busy), .done(done), .fail(fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cone as specified: a product of a bit and its next neighbour,
  // optionally pinned, then toggled by the bit two places on.
  function automatic logic [2:0] cone(input logic [2:0] q, input logic fe,
                                      input int fs, input logic fv);
    logic [2:0] r;
    for (int b = 0; b < 3; b++) begin
      logic t;
      t = q[b] & q[(b + 1) % 3];
      if (fe && fs == b) t = fv;
      r[b] = t ^ q[(b + 2) % 3];
    end
    return r;
  endfunction

  // Driver side: predict and queue, then present the inputs.
  task automatic offer(input logic [2:0] p, input logic [2:0] e, input bit from_idle);
    logic [2:0] r;
    r = cone(p, fault_en, int'(fault_sel), fault_val);
    if (from_idle) fail_acc = 0;
    fail_acc = fail_acc | (r != e);
    resp_q.push_back(r);
    fail_q.push_back(fail_acc);
    head_q.push_back(p[2]);
    pattern  = p;
    expected = e;
    start    = 1'b1;
  endtask

  // Monitor: compares serial traffic and completion flags.
  always @(negedge clk) begin
    if (rst_n) begin
      if (unload_left > 0 && scan_enable) begin
        got[unload_left-1] = scan_out;
        unload_left--;
        if (unload_left == 0) begin
          if (resp_q.size() == 0) chk(0, "R5 unexpected response", int'(got), -1);
          else begin
            logic [2:0] r;
            r = resp_q.pop_front();
            chk(got == r, "R5/R4 unloaded response", int'(got), int'(r));
          end
        end
      end
      if (busy && !scan_enable) begin
        if (head_q.size() == 0) chk(0, "R3 unexpected capture", 1, 0);
        else begin
          logic h;
          h = head_q.pop_front();
          chk(scan_out == h, "R2 tail holds first bit at capture", int'(scan_out), int'(h));
        end
        unload_left = L;
      end
      if (done) begin
        if (fail_q.size() == 0) chk(0, "R10 unexpected done", 1, 0);
        else begin
          logic f;
          f = fail_q.pop_front();
          chk(fail == f, "R6/R8 fail at done", int'(fail), int'(f));
        end
      end
    end
  end

  task automatic run_single(input logic [2:0] p, input logic [2:0] e, input bit noise);
    int bc;
    @(negedge clk);
    while (busy) @(negedge clk);
    offer(p, e, 1);
    @(negedge clk);
    start = 1'b0;
    chk(fail == 1'b0, "R8 fail cleared by idle start", int'(fail), 0);
    bc = 0;
    for (int k = 0; k < L; k++) begin
      if (k > 0) @(negedge clk);
      if (noise && k == 1) begin
        start = 1'b1; pattern = ~p; expected = ~e;  // R11 stray start
      end else if (noise && k == 2) begin
        start = 1'b0;
      end
      chk(scan_enable == 1'b1, "R2 shift enable during load", int'(scan_enable), 1);
      chk(scan_in == p[L-1-k], "R2 load bit order", int'(scan_in), int'(p[L-1-k]));
      if (busy) bc++;
    end
    start = 1'b0;
    @(negedge clk);
    chk(scan_enable == 1'b0, "R3 single capture cycle", int'(scan_enable), 0);
    if (busy) bc++;
    for (int k = 0; k < L; k++) begin
      @(negedge clk);
      chk(scan_enable == 1'b1, "R3 shift resumes", int'(scan_enable), 1);
      if (busy) bc++;
    end
    @(negedge clk);
    chk(done && !busy, "R10 done pulse with busy low", int'({done, busy}), 2);
    chk(bc == 2 * L + 1, "R10 busy length", bc, 2 * L + 1);
    @(negedge clk);
    chk(!done, "R10 done lasts one cycle", int'(done), 0);
  endtask

  task automatic run_pair(input logic [2:0] pa, input logic [2:0] ea,
                          input logic [2:0] pb, input logic [2:0] eb);
    int bc;
    int dn;
    @(negedge clk);
    while (busy) @(negedge clk);
    offer(pa, ea, 1);
    @(negedge clk);
    start = 1'b0;
    bc = 0;
    dn = 0;
    while (!(busy && !scan_enable)) begin
      if (busy) bc++;
      @(negedge clk);
    end
    bc++;
    offer(pb, eb, 0);  // R9 chained start in the capture cycle
    @(negedge clk);
    start = 1'b0;
    while (busy) begin
      bc++;
      if (done) dn++;
      @(negedge clk);
    end
    if (done) dn++;
    chk(bc == 3 * L + 2, "R9 overlapped busy length", bc, 3 * L + 2);
    chk(dn == 2, "R9 one done per pattern", dn, 2);
    chk(fail == fail_acc, "R8 fail after chained run", int'(fail), int'(fail_acc));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk({busy, done, fail, scan_enable} == 4'b0, "R1 reset outputs",
        int'({busy, done, fail, scan_enable}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, fail} == 3'b0, "R1 idle after reset", int'({busy, done, fail}), 0);

    // R4/R5 fault-free patterns with exact expectations
    run_single(3'b101, cone(3'b101, 0, 0, 0), 0);
    run_single(3'b111, cone(3'b111, 0, 0, 0), 0);
    run_single(3'b011, cone(3'b011, 0, 0, 0), 0);
    chk(fail == 1'b0, "R6 clean run leaves fail low", int'(fail), 0);

    // R6 wrong expectation is reported
    run_single(3'b100, cone(3'b100, 0, 0, 0) ^ 3'b010, 0);
    chk(fail == 1'b1, "R6 mismatch detected", int'(fail), 1);

    // R7 stuck-at-0 on net 1, excited by 111
    fault_en = 1'b1; fault_sel = 2'd1; fault_val = 1'b0;
    run_single(3'b111, cone(3'b111, 0, 0, 0), 0);
    chk(fail == 1'b1, "R7 stuck-at-0 detected", int'(fail), 1);
    // R7 same fault masked by 000
    run_single(3'b000, cone(3'b000, 0, 0, 0), 0);
    chk(fail == 1'b0, "R7 masked fault not flagged", int'(fail), 0);
    // R7 stuck-at-1 on net 0
    fault_sel = 2'd0; fault_val = 1'b1;
    run_single(3'b000, cone(3'b000, 0, 0, 0), 0);
    chk(fail == 1'b1, "R7 stuck-at-1 detected", int'(fail), 1);
    // R7 out-of-range select has no effect
    fault_sel = 2'd3;
    run_single(3'b111, cone(3'b111, 0, 0, 0), 0);
    chk(fail == 1'b0, "R7 out-of-range select inert", int'(fail), 0);
    fault_en = 1'b0; fault_sel = 2'd1; fault_val = 1'b0;
    run_single(3'b111, cone(3'b111, 0, 0, 0), 0);
    chk(fail == 1'b0, "R7 disabled fault inert", int'(fail), 0);

    // R11 stray start while shifting
    run_single(3'b110, cone(3'b110, 0, 0, 0), 1);
    chk(fail == 1'b0, "R11 stray start ignored", int'(fail), 0);

    // R9 chained patterns, R8 fail held over a clean second pattern
    run_pair(3'b101, cone(3'b101, 0, 0, 0), 3'b010, cone(3'b010, 0, 0, 0));
    run_pair(3'b011, ~cone(3'b011, 0, 0, 0), 3'b110, cone(3'b110, 0, 0, 0));
    chk(fail == 1'b1, "R8 sticky across chained pattern", int'(fail), 1);
    run_single(3'b001, cone(3'b001, 0, 0, 0), 0);
    chk(fail == 1'b0, "R8 cleared by next idle start", int'(fail), 0);

    repeat (3) @(negedge clk);
    chk(resp_q.size() == 0 && fail_q.size() == 0, "R5 scoreboard drained",
        resp_q.size() + fail_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule